// File: doc/BRIEF.md
# Mode-Aware Dual-Wordline Row Controller

This block drives the row strobes of a static memory array in which two neighbouring physical cells can be coupled to hold a single bit. Each column group has its own cell mode. In normal mode every cell holds its own bit. In high-speed mode a coupled pair is opened on both rows, which gives a stronger read and write. In dependable mode a coupled pair is read through one row only, for a larger noise margin. A write to a dependable group is always opened on both rows. Either paired mode halves the capacity of its group.

Every physical row has two wordlines, A and B. Each column group is wired to one of them on each row. Pairs in odd-numbered column groups start one row lower than pairs in even groups. The wiring is chosen so that opening both rows of one pair never opens both rows of a pair in any other group. The controller takes a request (group, row, read/write) and the mode table. It returns registered wordline strobes, a one-hot column-group select, an error flag, and an active-low coupling enable for each group. Mode writes go to a shadow table, which is copied into the live table only while no access is in flight.

Top module: `dwl_row_ctrl`

## Requirements
- R1: `pair_ctrl_n[g]` is 0 when group g's live mode is high-speed (01) or dependable (10), and 1 when it is normal (00) or reserved (11).
- R2: A normal-mode access to row r opens exactly one wordline, on row r.
- R3: A high-speed access, read or write, to logical row n opens both rows of the pair, base and base+1.
- R4: A dependable-mode read opens only the base row of the pair.
- R5: A dependable-mode write opens both rows of the pair, as a high-speed access does.
- R6: In a paired mode the pair base is 2n for even groups and 2n+1 for odd groups. Row r of group g uses wordline B when bit 2 of g is 1 and (r XOR g) is odd, or when bit 1 of g is 1 and (r XOR g) is even. In every other case it uses wordline A.
- R7: A request presented in cycle c drives its wordlines, and the one-hot `col_sel` bit of its group, during cycle c+2 only. With no request, all strobes are 0.
- R8: A request to a group in reserved mode, or a paired-mode row of `ROWS/2` or more (`ROWS/2-1` or more for odd groups), raises `acc_err` in cycle c+2 with no wordline and no column select.
- R9: A mode write reaches the live table only after a cycle in which there is no request and no access in its decode or strobe stage. An access in flight uses the old mode.
- R10: No wordline pattern ever opens both rows of a pair in a column group other than the selected one.
- R11: After reset all modes are normal, all strobes and `acc_err` are 0, and all `pair_ctrl_n` bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_group | input | $clog2(COL_GROUPS) | Column group of the access |
| req_row | input | $clog2(ROWS) | Physical row (normal mode) or logical pair index (paired modes) |
| cfg_we | input | 1 | Mode table write strobe |
| cfg_group | input | $clog2(COL_GROUPS) | Group whose mode is written |
| cfg_mode | input | 2 | New mode: 00 normal, 01 high-speed, 10 dependable, 11 reserved |
| wl_a | output | ROWS | Wordline A, one bit per row |
| wl_b | output | ROWS | Wordline B, one bit per row |
| pair_ctrl_n | output | COL_GROUPS | Active-low cell coupling enable, one bit per group |
| col_sel | output | COL_GROUPS | One-hot column group select, driven with the wordlines |
| acc_err | output | 1 | Rejected request flag |

## Verification
The assertions assume that the mode table is written only when the caller expects the change. Each request is a single-cycle pulse. The ordering rule on the live table holds even when requests run back to back. The stimulus separates random mode writes from accesses by idle cycles, so the bench's own mode copy matches the live table. A directed sequence then issues a mode write in the same cycle as a pair of back-to-back requests, to exercise the deferred update. Rows are biased toward the last pair of each group, where odd groups lose capacity, and reserved modes are mixed in.

// File: rtl/dwl_pkg.sv
package dwl_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'b00,
      MODE_FAST   = 2'b01,
      MODE_SAFE   = 2'b10,
      MODE_RSVD   = 2'b11
   } cell_mode_e;

   typedef enum logic [1:0] {
      ACC_NONE   = 2'b00,
      ACC_SINGLE = 2'b01,
      ACC_DUAL   = 2'b10
   } acc_kind_e;

   // Wordline wiring: 1 selects line B for column group grp on physical row.
   function automatic logic line_is_b(input int unsigned grp, input int unsigned row);
      int unsigned phase;
      int unsigned gsh;
      phase = grp ^ row;
      if (phase[0]) gsh = grp >> 2;
      else          gsh = grp >> 1;
      return gsh[0];
   endfunction

   function automatic logic mode_is_paired(input logic [1:0] m);
      return (m == MODE_FAST) || (m == MODE_SAFE);
   endfunction

endpackage

// File: rtl/dwl_mode_table.sv
module dwl_mode_table
   import dwl_pkg::*;
#(
   parameter int COL_GROUPS = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic [$clog2(COL_GROUPS)-1:0]     cfg_group,
   input  logic [1:0]                        cfg_mode,
   input  logic                              idle,
   output logic [COL_GROUPS-1:0][1:0]        act_mode,
   output logic [COL_GROUPS-1:0]             pair_ctrl_n
);
   localparam int GW = $clog2(COL_GROUPS);

   for (genvar g = 0; g < COL_GROUPS; g++) begin : g_grp
      logic [1:0] shadow_q;
      logic [1:0] live_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            shadow_q <= MODE_NORMAL;
         else if (cfg_we && (cfg_group == GW'(g)))
            shadow_q <= cfg_mode;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            live_q <= MODE_NORMAL;
         else if (idle)
            live_q <= shadow_q;
      end

      assign act_mode[g]    = live_q;
      assign pair_ctrl_n[g] = !mode_is_paired(live_q);
   end

endmodule

// File: rtl/dwl_addr_map.sv
module dwl_addr_map
   import dwl_pkg::*;
#(
   parameter int ROWS       = 128,
   parameter int COL_GROUPS = 8
) (
   input  logic [$clog2(COL_GROUPS)-1:0] grp,
   input  logic [$clog2(ROWS)-1:0]       row,
   input  logic                          write,
   input  logic [1:0]                    mode,
   output acc_kind_e                     kind,
   output logic [$clog2(ROWS)-1:0]       row0,
   output logic [$clog2(ROWS)-1:0]       row1,
   output logic                          err
);
   localparam int RW = $clog2(ROWS);

   logic shifted;
   logic paired;
   logic over;

   always_comb begin
      shifted = grp[0];
      paired  = mode_is_paired(mode);
      // Odd groups lose their last pair: it would run past the final row.
      over    = row[RW-1] || (shifted && (row[RW-2:0] == {(RW-1){1'b1}}));
      err     = (mode == MODE_RSVD) || (paired && over);
      row0    = paired ? {row[RW-2:0], shifted} : row;
      row1    = row0 + RW'(1);
      if (err)
         kind = ACC_NONE;
      else if ((mode == MODE_FAST) || ((mode == MODE_SAFE) && write))
         kind = ACC_DUAL;
      else
         kind = ACC_SINGLE;
   end

endmodule

// File: rtl/dwl_wl_driver.sv
module dwl_wl_driver
   import dwl_pkg::*;
#(
   parameter int ROWS       = 128,
   parameter int COL_GROUPS = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          go,
   input  acc_kind_e                     kind,
   input  logic [$clog2(COL_GROUPS)-1:0] grp,
   input  logic [$clog2(ROWS)-1:0]       row0,
   input  logic [$clog2(ROWS)-1:0]       row1,
   output logic [ROWS-1:0]               wl_a,
   output logic [ROWS-1:0]               wl_b
);
   localparam int RW = $clog2(ROWS);

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic hit;
      logic to_b;
      logic a_q;
      logic b_q;

      always_comb begin
         hit  = go && ((row0 == RW'(r)) || ((kind == ACC_DUAL) && (row1 == RW'(r))));
         to_b = line_is_b(32'(grp), r);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
         end else begin
            a_q <= hit && !to_b;
            b_q <= hit && to_b;
         end
      end

      assign wl_a[r] = a_q;
      assign wl_b[r] = b_q;
   end

endmodule

// File: rtl/dwl_row_ctrl.sv
module dwl_row_ctrl
   import dwl_pkg::*;
#(
   parameter int ROWS       = 128,
   parameter int COL_GROUPS = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic                          req_write,
   input  logic [$clog2(COL_GROUPS)-1:0] req_group,
   input  logic [$clog2(ROWS)-1:0]       req_row,
   input  logic                          cfg_we,
   input  logic [$clog2(COL_GROUPS)-1:0] cfg_group,
   input  logic [1:0]                    cfg_mode,
   output logic [ROWS-1:0]               wl_a,
   output logic [ROWS-1:0]               wl_b,
   output logic [COL_GROUPS-1:0]         pair_ctrl_n,
   output logic [COL_GROUPS-1:0]         col_sel,
   output logic                          acc_err
);
   localparam int RW = $clog2(ROWS);
   localparam int GW = $clog2(COL_GROUPS);

   if ((ROWS < 4) || ((ROWS & (ROWS - 1)) != 0)) begin : g_bad_rows
      $error("dwl_row_ctrl: ROWS must be a power of two of at least 4");
   end
   if ((COL_GROUPS != 2) && (COL_GROUPS != 4) && (COL_GROUPS != 8)) begin : g_bad_groups
      $error("dwl_row_ctrl: COL_GROUPS must be 2, 4 or 8 for a half-select-free wiring");
   end

   // Decode stage
   logic          s1_valid;
   logic          s1_write;
   logic [GW-1:0] s1_grp;
   logic [RW-1:0] s1_row;
   logic          s2_valid;
   logic          idle;

   logic [COL_GROUPS-1:0][1:0] act_mode;
   acc_kind_e     map_kind;
   logic [RW-1:0] map_row0;
   logic [RW-1:0] map_row1;
   logic          map_err;
   logic          map_go;
   logic          err_q;

   assign idle = !req_valid && !s1_valid && !s2_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_write <= 1'b0;
         s1_grp   <= '0;
         s1_row   <= '0;
      end else begin
         s1_valid <= req_valid;
         if (req_valid) begin
            s1_write <= req_write;
            s1_grp   <= req_group;
            s1_row   <= req_row;
         end
      end
   end

   dwl_mode_table #(.COL_GROUPS(COL_GROUPS)) u_modes (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .cfg_group   (cfg_group),
      .cfg_mode    (cfg_mode),
      .idle        (idle),
      .act_mode    (act_mode),
      .pair_ctrl_n (pair_ctrl_n)
   );

   dwl_addr_map #(.ROWS(ROWS), .COL_GROUPS(COL_GROUPS)) u_map (
      .grp   (s1_grp),
      .row   (s1_row),
      .write (s1_write),
      .mode  (act_mode[s1_grp]),
      .kind  (map_kind),
      .row0  (map_row0),
      .row1  (map_row1),
      .err   (map_err)
   );

   assign map_go = s1_valid && !map_err;

   // Strobe stage
   dwl_wl_driver #(.ROWS(ROWS), .COL_GROUPS(COL_GROUPS)) u_drv (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (map_go),
      .kind  (map_kind),
      .grp   (s1_grp),
      .row0  (map_row0),
      .row1  (map_row1),
      .wl_a  (wl_a),
      .wl_b  (wl_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         s2_valid <= s1_valid;
         err_q    <= s1_valid && map_err;
      end
   end

   for (genvar g = 0; g < COL_GROUPS; g++) begin : g_sel
      logic sel_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sel_q <= 1'b0;
         else        sel_q <= map_go && (s1_grp == GW'(g));
      end
      assign col_sel[g] = sel_q;
   end

   assign acc_err = err_q;

endmodule

// File: rtl/dwl_row_ctrl_chk.sv
module dwl_row_ctrl_chk
   import dwl_pkg::*;
#(
   parameter int ROWS       = 128,
   parameter int COL_GROUPS = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic [ROWS-1:0]       wl_a,
   input logic [ROWS-1:0]       wl_b,
   input logic [COL_GROUPS-1:0] pair_ctrl_n,
   input logic [COL_GROUPS-1:0] col_sel,
   input logic                  acc_err
);
   logic [COL_GROUPS-1:0] full_pair;
   logic [2*ROWS-1:0]     all_wl;

   assign all_wl = {wl_a, wl_b};

   // Groups whose pair has both of its rows reached by the current strobes.
   always_comb begin
      full_pair = '0;
      for (int h = 0; h < COL_GROUPS; h++) begin
         for (int b = h % 2; b + 1 < ROWS; b += 2) begin
            logic ra;
            logic rb;
            ra = line_is_b(h, b)     ? wl_b[b]     : wl_a[b];
            rb = line_is_b(h, b + 1) ? wl_b[b + 1] : wl_a[b + 1];
            if (ra && rb) full_pair[h] = 1'b1;
         end
      end
   end

   p_at_most_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(all_wl) <= 2);

   p_dual_pairs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(all_wl) == 2) |-> ((full_pair & col_sel) != '0));

   p_dual_coupled_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(all_wl) == 2) |-> ((pair_ctrl_n & col_sel) == '0));

   p_wl_from_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (all_wl != '0) |-> $past(req_valid, 2));

   p_sel_with_wl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (all_wl != '0) |-> ($countones(col_sel) == 1));

   p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col_sel));

   p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |-> ((all_wl == '0) && (col_sel == '0)));

   p_ctrl_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> $stable(pair_ctrl_n));

   p_ctrl_hold_wl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (all_wl != '0) |=> $stable(pair_ctrl_n));

   p_no_half_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (full_pair & ~col_sel) == '0);

endmodule

bind dwl_row_ctrl dwl_row_ctrl_chk #(.ROWS(ROWS), .COL_GROUPS(COL_GROUPS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .wl_a        (wl_a),
   .wl_b        (wl_b),
   .pair_ctrl_n (pair_ctrl_n),
   .col_sel     (col_sel),
   .acc_err     (acc_err)
);

// File: tb/test_dwl_row_ctrl.sv
`timescale 1ns/1ps
module test_dwl_row_ctrl;
   localparam int ROWS = 128;
   localparam int GRPS = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_write = 1'b0;
   logic [2:0]      req_group = '0;
   logic [6:0]      req_row = '0;
   logic            cfg_we = 1'b0;
   logic [2:0]      cfg_group = '0;
   logic [1:0]      cfg_mode = '0;
   logic [ROWS-1:0] wl_a;
   logic [ROWS-1:0] wl_b;
   logic [GRPS-1:0] pair_ctrl_n;
   logic [GRPS-1:0] col_sel;
   logic            acc_err;

   always #2 clk = ~clk;

   dwl_row_ctrl #(.ROWS(ROWS), .COL_GROUPS(GRPS)) i_dwl_row_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_group(req_group), .req_row(req_row), .cfg_we(cfg_we),
      .cfg_group(cfg_group), .cfg_mode(cfg_mode), .wl_a(wl_a), .wl_b(wl_b),
      .pair_ctrl_n(pair_ctrl_n), .col_sel(col_sel), .acc_err(acc_err)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int bmode [GRPS];

   task automatic chk(input string tag, input string what,
                      input logic [2*ROWS+GRPS:0] got, input logic [2*ROWS+GRPS:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   function automatic bit f_line_b(int g, int r);
      if (((g ^ r) & 1) != 0) return ((g >> 2) & 1) != 0;
      return ((g >> 1) & 1) != 0;
   endfunction

   function automatic logic [GRPS-1:0] f_ctrl();
      logic [GRPS-1:0] v;
      for (int g = 0; g < GRPS; g++) v[g] = !(bmode[g] == 1 || bmode[g] == 2);
      return v;
   endfunction

   function automatic bit f_half(logic [ROWS-1:0] wa, logic [ROWS-1:0] wb, int sel);
      for (int h = 0; h < GRPS; h++) begin
         if (h != sel) begin
            for (int b = h & 1; b + 1 < ROWS; b += 2) begin
               bit ra;
               bit rb;
               ra = f_line_b(h, b) ? wb[b] : wa[b];
               rb = f_line_b(h, b + 1) ? wb[b + 1] : wa[b + 1];
               if (ra && rb) return 1'b1;
            end
         end
      end
      return 1'b0;
   endfunction

   task automatic predict(input int g, input int row, input bit we,
                          output logic [ROWS-1:0] ea, output logic [ROWS-1:0] eb,
                          output bit eerr, output string tag);
      int m;
      int sh;
      int r0;
      int n;
      m = bmode[g]; sh = g & 1; ea = '0; eb = '0; eerr = 0; r0 = 0; n = 0;
      if (m == 3) begin
         eerr = 1; tag = "R8";
      end else if (m == 0) begin
         r0 = row; n = 1; tag = "R2";
      end else if (row >= ROWS/2 - sh) begin
         eerr = 1; tag = "R8";
      end else begin
         r0 = 2*row + sh;
         n = (m == 1 || we) ? 2 : 1;
         tag = (m == 1) ? "R3" : (we ? "R5" : "R4");
      end
      for (int k = 0; k < n; k++) begin
         if (f_line_b(g, r0 + k)) eb[r0 + k] = 1'b1;
         else                     ea[r0 + k] = 1'b1;
      end
   endtask

   // Caller is at a falling edge; returns at a falling edge with the block idle.
   task automatic run_access(input int g, input int row, input bit we, input string over);
      logic [ROWS-1:0] ea;
      logic [ROWS-1:0] eb;
      logic [GRPS-1:0] esel;
      bit    eerr;
      string tag;
      predict(g, row, we, ea, eb, eerr, tag);
      if (over != "") tag = over;
      esel = eerr ? '0 : (GRPS'(1) << g);
      req_valid = 1'b1; req_write = we; req_group = 3'(g); req_row = 7'(row);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R7", "strobes one cycle after request", {wl_a, wl_b, col_sel}, '0);
      @(negedge clk);
      chk(tag, "wordlines", {wl_a, wl_b}, {ea, eb});
      chk(tag, "column select", col_sel, esel);
      chk(tag, "error flag", acc_err, eerr);
      chk("R10", "half-select of another group", f_half(wl_a, wl_b, g), 0);
      @(negedge clk);
      chk("R7", "strobes released", {wl_a, wl_b, col_sel, acc_err}, '0);
   endtask

   task automatic set_mode(input int g, input int m);
      cfg_we = 1'b1; cfg_group = 3'(g); cfg_mode = 2'(m);
      @(negedge clk);
      cfg_we = 1'b0;
      repeat (3) @(negedge clk);
      bmode[g] = m;
      chk("R1", "coupling control", pair_ctrl_n, f_ctrl());
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, got hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int g = 0; g < GRPS; g++) bmode[g] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk("R11", "strobes after reset", {wl_a, wl_b, col_sel, acc_err}, '0);
      chk("R11", "coupling off after reset", pair_ctrl_n, {GRPS{1'b1}});

      // R2 normal accesses, including the last row
      run_access(0, 0, 1'b0, "");
      run_access(7, 127, 1'b1, "");
      run_access(5, 64, 1'b0, "");

      // R6 shifted group pair base and wiring (rows 1,2 on line A)
      set_mode(1, 1);
      run_access(1, 0, 1'b0, "R6");
      run_access(1, 62, 1'b1, "R6");
      run_access(1, 63, 1'b0, "");        // R8: beyond odd-group capacity
      set_mode(0, 1);
      run_access(0, 63, 1'b0, "R6");      // last pair of an even group
      run_access(0, 64, 1'b1, "");        // R8
      // R4 / R5 dependable read and write
      set_mode(4, 2);
      run_access(4, 10, 1'b0, "");
      run_access(4, 10, 1'b1, "");
      set_mode(7, 2);
      run_access(7, 62, 1'b0, "");
      run_access(7, 62, 1'b1, "");
      // R8 reserved mode, coupling stays off (R1)
      set_mode(6, 3);
      run_access(6, 3, 1'b0, "");

      // R9: mode write alongside back-to-back requests
      req_valid = 1'b1; req_write = 1'b0; req_group = 3'd2; req_row = 7'd5;
      cfg_we = 1'b1; cfg_group = 3'd2; cfg_mode = 2'd1;
      @(negedge clk);
      cfg_we = 1'b0; req_row = 7'd6;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9", "in-flight access keeps old mode", {wl_a, wl_b},
          {{ROWS{1'b0}} | (ROWS'(f_line_b(2, 5) ? 0 : 1) << 5),
           {ROWS{1'b0}} | (ROWS'(f_line_b(2, 5) ? 1 : 0) << 5)});
      @(negedge clk);
      chk("R9", "second in-flight access keeps old mode", {wl_a, wl_b},
          {{ROWS{1'b0}} | (ROWS'(f_line_b(2, 6) ? 0 : 1) << 6),
           {ROWS{1'b0}} | (ROWS'(f_line_b(2, 6) ? 1 : 0) << 6)});
      chk("R9", "coupling unchanged while busy", pair_ctrl_n[2], 1'b1);
      repeat (3) @(negedge clk);
      bmode[2] = 1;
      chk("R9", "mode applied once idle", pair_ctrl_n, f_ctrl());
      run_access(2, 5, 1'b0, "R9");

      // Random mix
      for (int i = 0; i < 400; i++) begin
         int g;
         int row;
         int pick;
         if ($urandom_range(0, 7) == 0)
            set_mode($urandom_range(0, GRPS-1), $urandom_range(0, 3));
         g = $urandom_range(0, GRPS-1);
         pick = $urandom_range(0, 9);
         case (pick)
            0: row = 62;
            1: row = 63;
            2: row = 64;
            3: row = 127;
            4: row = 0;
            default: row = $urandom_range(0, ROWS-1);
         endcase
         run_access(g, row, 1'($urandom_range(0, 1)), "");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule